// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 65,536 sixteen-bit words. The RAM has two independent byte-lane enables. A requester presents a read or write, a 16-bit word address, 16 bits of write data and a two-bit lane mask through a valid/ready handshake. The controller then runs one fixed-length access on the RAM's active-low strobes: chip enable, write enable, output enable and the low and high lane enables. Every strobe and address bit comes straight from a flop.

The access length is a parameter. The active phase lasts `WAIT_CYC` clock cycles, so it can be set to cover the RAM's address-to-data time at the chosen clock rate. Address and lane enables stay fixed for the whole access. The shared data bus is split into an output word, an output-enable and an input word. The controller drives the bus only while a write strobe is low, so it never drives against a reading RAM. A read returns a single-cycle valid pulse with the captured word. Lanes that the mask leaves out read as zero. A request with an empty mask finishes in one cycle and never selects the chip.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset (synchronous, active high), and for as long as it is held, `sram_ce_n`, `sram_we_n`, `sram_oe_n`, `sram_lb_n` and `sram_ub_n` are high, `sram_dq_oe` is low, `req_ready` is high and `rd_valid` is low. A reset during an access abandons the access and returns to this state on the next clock.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. For a request whose mask is not zero, `req_ready` then reads low for exactly `WAIT_CYC+2` cycles. Request inputs that change during that time have no effect.
- R3: Write sequence, counting cycles after the accepting edge. In cycle 0, chip enable is low and write and output enable are high. In cycles 1 to `WAIT_CYC`, chip enable and write enable are low and output enable is high. In cycle `WAIT_CYC+1`, all strobes are high.
- R4: A read follows the same sequence as a write, except that output enable is low in cycles 1 to `WAIT_CYC` and write enable stays high throughout.
- R5: Mask bit 0 selects the low lane (data bits 7:0) and mask bit 1 selects the high lane (bits 15:8). `sram_lb_n` equals the inverse of mask bit 0 and `sram_ub_n` equals the inverse of mask bit 1. These values, and `sram_addr`, hold the accepted request from cycle 0 through cycle `WAIT_CYC` without change.
- R6: `sram_dq_oe` is high only when write enable and chip enable are both low. While it is high, `sram_dq_out` carries the accepted write data.
- R7: A write updates only the selected lanes. The other byte of the addressed word keeps its previous contents.
- R8: A read asserts `rd_valid` for one cycle, in cycle `WAIT_CYC+1`. In that cycle `rd_data` holds the word sampled on `sram_dq_in` at the end of the active phase, with each unselected lane forced to zero.
- R9: A request with a zero mask keeps chip enable and both lane enables high. It holds `req_ready` low for one cycle only. If it is a read, it pulses `rd_valid` with `rd_data` equal to zero in cycle 0.
- R10: Write enable and output enable are never low together, and neither is low while chip enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 low byte, bit 1 high byte |
| rd_valid | output | 1 | One-cycle read-return pulse |
| rd_data | output | 16 | Read-return word, unselected lanes zero |
| sram_addr | output | 16 | RAM address lines |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_lb_n | output | 1 | RAM low byte-lane enable, active low |
| sram_ub_n | output | 1 | RAM high byte-lane enable, active low |
| sram_dq_out | output | 16 | Data the controller puts on the bus |
| sram_dq_oe | output | 1 | Controller bus driver enable |
| sram_dq_in | input | 16 | Data seen on the bus |

## Verification
The bench targets single-lane writes followed by full-word reads. A controller that ignored the mask would overwrite the byte that should survive. It also reads with one lane off, where a design that passed the raw bus word would return stale data in the unselected byte. Empty-mask requests are checked to return without chip select and with a zero read word; a wrong design would touch the RAM or hang the handshake. The bench scrambles the request inputs during each access, and a controller that did not hold its latched address and lanes would move the strobed location. A bus model flags any cycle in which both sides drive, and a reset issued mid-write must leave every strobe idle on the next clock.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  localparam int unsigned RAM_AW = 16;
  localparam int unsigned RAM_DW = 16;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETUP   = 3'd1,
    PH_ACTIVE  = 3'd2,
    PH_RECOVER = 3'd3,
    PH_SKIP    = 3'd4
  } phase_e;

  function automatic logic phase_selects(input phase_e p);
    return (p == PH_SETUP) || (p == PH_ACTIVE);
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int unsigned WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic last
);
  localparam int unsigned CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CW-1:0] START = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= START;
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == '0);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= START) else $error("wait counter out of range"); // R3
endmodule

// File: rtl/sram_req_fsm.sv
module sram_req_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned MASK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [MASK_W-1:0] req_mask,
  input  logic              timer_last,
  output logic              req_ready,
  output logic              accept,
  output logic              wr_q,
  output phase_e            phase,
  output phase_e            phase_nxt,
  output logic              timer_load,
  output logic              timer_run,
  output logic              rd_capture,
  output logic              rd_empty
);
  logic empty_mask;

  assign req_ready  = (phase == PH_IDLE);
  assign accept     = req_valid && req_ready;
  assign empty_mask = (req_mask == '0);

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE:    if (req_valid) phase_nxt = empty_mask ? PH_SKIP : PH_SETUP;
      PH_SETUP:   phase_nxt = PH_ACTIVE;
      PH_ACTIVE:  if (timer_last) phase_nxt = PH_RECOVER;
      PH_RECOVER: phase_nxt = PH_IDLE;
      PH_SKIP:    phase_nxt = PH_IDLE;
      default:    phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      wr_q  <= 1'b0;
    end else begin
      phase <= phase_nxt;
      if (accept) wr_q <= req_write;
    end
  end

  assign timer_load = (phase == PH_SETUP);
  assign timer_run  = (phase == PH_ACTIVE);
  assign rd_capture = (phase == PH_ACTIVE) && timer_last && !wr_q;
  assign rd_empty   = accept && empty_mask && !req_write;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready) else $error("ready stayed high after accept"); // R2
  AST_SKIP_SHORT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |=> req_ready) else $error("empty request not one cycle"); // R9
endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_mask,
  input  phase_e           phase_nxt,
  input  logic             wr_q,
  output logic [AW-1:0]    ram_addr,
  output logic             ram_ce_n,
  output logic             ram_we_n,
  output logic             ram_oe_n,
  output logic [LANES-1:0] ram_lane_n,
  output logic [DW-1:0]    ram_dout,
  output logic             ram_doe
);
  logic sel_nxt, act_nxt;

  assign sel_nxt = phase_selects(phase_nxt);
  assign act_nxt = (phase_nxt == PH_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr <= '0;
      ram_dout <= '0;
    end else if (accept) begin
      ram_addr <= req_addr;
      ram_dout <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_ce_n <= 1'b1;
      ram_we_n <= 1'b1;
      ram_oe_n <= 1'b1;
      ram_doe  <= 1'b0;
    end else begin
      ram_ce_n <= !sel_nxt;
      ram_we_n <= !(act_nxt && wr_q);
      ram_oe_n <= !(act_nxt && !wr_q);
      ram_doe  <= act_nxt && wr_q;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        ram_lane_n[g] <= 1'b1;
      end else if (accept) begin
        ram_lane_n[g] <= !req_mask[g];
      end else if (!sel_nxt) begin
        ram_lane_n[g] <= 1'b1;
      end
    end
  end

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!ram_we_n && !ram_oe_n)) else $error("write and output enable both low"); // R10
  AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (rst)
    (!ram_we_n || !ram_oe_n) |-> !ram_ce_n) else $error("strobe without chip enable"); // R10
  AST_BUS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    ram_doe |-> (!ram_we_n && !ram_ce_n)) else $error("bus driven outside write"); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ram_ce_n && !$past(ram_ce_n)) |-> ($stable(ram_addr) && $stable(ram_lane_n)))
    else $error("address or lanes moved during access"); // R5
  AST_NO_EMPTY_SELECT: assert property (@(posedge clk) disable iff (rst)
    (&ram_lane_n) |-> ram_ce_n) else $error("chip selected with no lane"); // R9
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DW    = 16,
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic             empty_rd,
  input  logic [LANES-1:0] lane_n,
  input  logic [DW-1:0]    dq_in,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data
);
  localparam int unsigned LW = DW / LANES;

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= capture || empty_rd;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_data[g*LW +: LW] <= '0;
      end else if (capture) begin
        rd_data[g*LW +: LW] <= lane_n[g] ? '0 : dq_in[g*LW +: LW];
      end else if (empty_rd) begin
        rd_data[g*LW +: LW] <= '0;
      end
    end
  end

  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid) else $error("read valid longer than one cycle"); // R8
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = RAM_AW,
  parameter int unsigned DATA_W   = RAM_DW,
  parameter int unsigned WAIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int unsigned LANES = 2;

  logic             accept, wr_q, timer_last, timer_load, timer_run;
  logic             rd_capture, rd_empty;
  logic [LANES-1:0] lane_n;
  phase_e           phase, phase_nxt;

  sram_req_fsm #(.MASK_W(LANES)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_mask   (req_mask),
    .timer_last (timer_last),
    .req_ready  (req_ready),
    .accept     (accept),
    .wr_q       (wr_q),
    .phase      (phase),
    .phase_nxt  (phase_nxt),
    .timer_load (timer_load),
    .timer_run  (timer_run),
    .rd_capture (rd_capture),
    .rd_empty   (rd_empty)
  );

  sram_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (timer_load),
    .run  (timer_run),
    .last (timer_last)
  );

  sram_pin_drive #(.AW(ADDR_W), .DW(DATA_W), .LANES(LANES)) u_pins (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mask   (req_mask),
    .phase_nxt  (phase_nxt),
    .wr_q       (wr_q),
    .ram_addr   (sram_addr),
    .ram_ce_n   (sram_ce_n),
    .ram_we_n   (sram_we_n),
    .ram_oe_n   (sram_oe_n),
    .ram_lane_n (lane_n),
    .ram_dout   (sram_dq_out),
    .ram_doe    (sram_dq_oe)
  );

  sram_rd_capture #(.DW(DATA_W), .LANES(LANES)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .capture  (rd_capture),
    .empty_rd (rd_empty),
    .lane_n   (lane_n),
    .dq_in    (sram_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign sram_lb_n = lane_n[0];
  assign sram_ub_n = lane_n[1];

  AST_IDLE_WHILE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !sram_ce_n |-> !req_ready) else $error("ready high during access"); // R2
  AST_READ_AFTER_OE: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && phase == PH_RECOVER) |-> $past(!sram_oe_n)) else $error("read return without output enable"); // R8
endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
  localparam int W = 3;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [15:0] data;
    logic [1:0]  mask;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 16'h0010, 16'hA1B2, 2'b11, 16'h0000},
    '{1'b0, 16'h0010, 16'h0000, 2'b11, 16'hA1B2},
    '{1'b1, 16'h0010, 16'hFFCC, 2'b01, 16'h0000},
    '{1'b0, 16'h0010, 16'h0000, 2'b11, 16'hA1CC},
    '{1'b1, 16'h0010, 16'h5500, 2'b10, 16'h0000},
    '{1'b0, 16'h0010, 16'h0000, 2'b11, 16'h55CC},
    '{1'b0, 16'h0010, 16'h0000, 2'b01, 16'h00CC},
    '{1'b0, 16'h0010, 16'h0000, 2'b10, 16'h5500},
    '{1'b1, 16'hFFFF, 16'h1234, 2'b11, 16'h0000},
    '{1'b0, 16'hFFFF, 16'h0000, 2'b11, 16'h1234},
    '{1'b1, 16'h0000, 16'hBEEF, 2'b00, 16'h0000},
    '{1'b0, 16'h0000, 16'h0000, 2'b11, 16'h0000},
    '{1'b0, 16'h0010, 16'h0000, 2'b00, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic req_ready, rd_valid, ce_n, we_n, oe_n, lb_n, ub_n, dq_oe;
  logic [15:0] rd_data, s_addr, dq_out, dq_in;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  sram_lane_ctrl #(.WAIT_CYC(W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_addr(s_addr), .sram_ce_n(ce_n), .sram_we_n(we_n), .sram_oe_n(oe_n),
    .sram_lb_n(lb_n), .sram_ub_n(ub_n), .sram_dq_out(dq_out),
    .sram_dq_oe(dq_oe), .sram_dq_in(dq_in)
  );

  // RAM model: byte-lane writes, lanes float unless read-selected
  logic [15:0] mem [int];
  logic rd_lo, rd_hi;

  function automatic logic [15:0] peek(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
  endfunction

  assign rd_lo = !ce_n && !oe_n && we_n && !lb_n;
  assign rd_hi = !ce_n && !oe_n && we_n && !ub_n;
  always @(*) begin
    dq_in[7:0]  = rd_lo ? peek(s_addr) >> 0 : 8'hzz;
    dq_in[15:8] = rd_hi ? peek(s_addr) >> 8 : 8'hzz;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !ce_n && !we_n) begin
      logic [15:0] w;
      w = peek(s_addr);
      if (!lb_n) w[7:0]  = dq_out[7:0];
      if (!ub_n) w[15:8] = dq_out[15:8];
      mem[int'(s_addr)] = w;
    end
    if (dq_oe && (rd_lo || rd_hi))
      chk(1'b0, "R6 bus contention", 32'(dq_oe), 32'h0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [5:0] pins();
    return {ce_n, we_n, oe_n, ub_n, lb_n, dq_oe};
  endfunction

  task automatic run_acc(input vec_t v);
    logic [5:0] e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_addr = v.addr;
    req_wdata = v.data; req_mask = v.mask;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~v.addr; req_wdata = ~v.data; req_mask = ~v.mask;
    if (v.mask == 2'b00) begin
      chk(pins() == 6'b111110, "R9 empty mask strobes", 32'(pins()), 32'h3E);
      chk(!req_ready, "R9 busy one cycle", 32'(req_ready), 32'h0);
      if (!v.wr) chk(rd_valid && rd_data == 16'h0, "R9 empty read return",
                     {15'h0, rd_valid, rd_data}, 32'h10000);
      @(negedge clk);
      chk(req_ready, "R9 ready back", 32'(req_ready), 32'h1);
      return;
    end
    e = {1'b0, 1'b1, 1'b1, !v.mask[1], !v.mask[0], 1'b0};
    chk(pins() == e, v.wr ? "R3 setup strobes" : "R4 setup strobes", 32'(pins()), 32'(e));
    chk(s_addr == v.addr, "R5 address", 32'(s_addr), 32'(v.addr));
    chk(!req_ready, "R2 busy", 32'(req_ready), 32'h0);
    for (int i = 1; i <= W; i++) begin
      @(negedge clk);
      e = v.wr ? {1'b0, 1'b0, 1'b1, !v.mask[1], !v.mask[0], 1'b1}
               : {1'b0, 1'b1, 1'b0, !v.mask[1], !v.mask[0], 1'b0};
      chk(pins() == e, v.wr ? "R3 active strobes" : "R4 active strobes", 32'(pins()), 32'(e));
      chk(s_addr == v.addr, "R5 address held", 32'(s_addr), 32'(v.addr));
      if (v.wr) chk(dq_out == v.data, "R6 write data", 32'(dq_out), 32'(v.data));
      chk(!req_ready && !rd_valid, "R2 busy active", {30'h0, req_ready, rd_valid}, 32'h0);
    end
    @(negedge clk);
    chk(pins() == 6'b111110, "R3 recovery strobes", 32'(pins()), 32'h3E);
    chk(!req_ready, "R2 busy recovery", 32'(req_ready), 32'h0);
    if (v.wr) chk(!rd_valid, "R8 no return on write", 32'(rd_valid), 32'h0);
    else chk(rd_valid && rd_data == v.exp, "R8 read return",
             {15'h0, rd_valid, rd_data}, {16'h1, v.exp});
    @(negedge clk);
    chk(req_ready && !rd_valid, "R2 ready after access / R8 pulse",
        {30'h0, req_ready, rd_valid}, 32'h2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pins() == 6'b111110, "R1 reset strobes", 32'(pins()), 32'h3E);
    chk(req_ready && !rd_valid, "R1 reset handshake", {30'h0, req_ready, rd_valid}, 32'h2);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) run_acc(TBL[k]);

    // R7: upper byte survived the low-only write, seen in the memory model
    chk(peek(16'h0010) == 16'h55CC, "R7 unselected byte kept", 32'(peek(16'h0010)), 32'h55CC);
    chk(peek(16'h0000) == 16'h0000, "R9 empty write ignored", 32'(peek(16'h0000)), 32'h0);

    // R1: reset in the middle of a write
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0020;
    req_wdata = 16'h7777; req_mask = 2'b11;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!we_n, "R3 write strobe before reset", 32'(we_n), 32'h0);
    rst = 1'b1;
    @(negedge clk);
    chk(pins() == 6'b111110, "R1 reset mid-access", 32'(pins()), 32'h3E);
    chk(req_ready, "R1 ready after reset", 32'(req_ready), 32'h1);
    rst = 1'b0;

    // R10 spot check through one more read after recovery
    run_acc('{1'b0, 16'h0010, 16'h0000, 2'b11, 16'h55CC});
    chk(!(!we_n && !oe_n), "R10 strobes exclusive", {30'h0, we_n, oe_n}, 32'h3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule